// File: doc/BRIEF.md
# Character-Cell Raster Timing Generator

This block produces the scan timing for a character-cell display controller. Each clock is one character time. Three counters run inside it: a character position along the line, a scan line within the current character row, and the character row within the frame. The totals, displayed extents, sync positions and sync widths come as parallel inputs from a register file that lives elsewhere. From these the block derives horizontal and vertical sync pulses, a display-enable window, a 14-bit refresh address for character memory and a 5-bit scan-line address for the glyph generator.

A 16-bit video memory address is also formed. It puts the two top refresh-address bits over three scan-line bits, then the low ten refresh-address bits, then a byte-phase bit that comes in from outside. A 3-bit variant input selects how a programmed sync width of zero is read, and whether the vertical width can be programmed at all. Every end-of-count test compares with greater-or-equal. As a result, a register that shrinks below a running count ends that count at its next step instead of letting it run past the end.

Top module: `crt_raster_gen`

## Requirements
- R1: While rst_ni is low, ma_o, ra_o and vid_addr_o[15:1] are zero and hsync_o and vsync_o are low. On the first rising clock after release, the character count steps, so ma_o reads 1 when h_total_i is at least 1.
- R2: The character count runs from 0 and returns to 0 on the clock after it is at or above h_total_i. Within a scan line, ma_o rises by one each clock, wrapping modulo 2^14.
- R3: At the end of a line, ra_o rises by one and ma_o restarts at the row base address. When ra_o is at or above max_scan_i at the end of a line, the next row begins: ra_o goes to 0, the row count rises by one (modulo 128), and the row base and ma_o become the old base plus h_disp_i.
- R4: When the last line of a row ends with the row count at or above v_total_i: if v_adj_i is 0, the frame restarts. Otherwise v_adj_i extra lines follow, with ra_o counting 0 to v_adj_i-1 and the row count one above the last row. The frame restarts at the end of the adjust line for which ra_o+1 is at or above v_adj_i.
- R5: On a frame restart, the character count, ra_o and the row count go to 0, and ma_o and the row base load start_addr_i. After reset, the first frame starts from address 0.
- R6: de_o is high exactly when the character count is below h_disp_i and the row count is below v_disp_i. It follows the inputs in the same cycle.
- R7: hsync_o goes high in the cycle in which the character count becomes equal to h_sync_pos_i, if the decoded horizontal width w is nonzero. It stays high for w cycles. A fresh match during a pulse restarts the pulse.
- R8: The horizontal width is the value of sync_width_i[3:0]. A zero in that field gives no pulse for variant_i 0 and 1, and 16 for variant_i 2 and above.
- R9: vsync_o goes high at the start of a line that begins with ra_o equal to 0 and a row count equal to v_sync_pos_i. It stays high for the decoded vertical width in lines, and changes only at line boundaries.
- R10: The vertical width is the value of sync_width_i[7:4], with zero read as 16, for variant_i 0 and for 3 and above. For variant_i 1 and 2, the vertical width is 16 lines whatever the value of sync_width_i[7:4].
- R11: vid_addr_o equals {ma_o[13:12], ra_o[2:0], ma_o[9:0], phase_i}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| variant_i | input | 3 | Sync-width interpretation select |
| h_total_i | input | 8 | Characters per line minus one |
| h_disp_i | input | 8 | Displayed characters per line |
| h_sync_pos_i | input | 8 | Character position where hsync starts |
| sync_width_i | input | 8 | [3:0] horizontal width, [7:4] vertical width |
| v_total_i | input | 7 | Character rows per frame minus one |
| v_disp_i | input | 7 | Displayed character rows |
| v_sync_pos_i | input | 7 | Row where vsync starts |
| v_adj_i | input | 5 | Extra scan lines after the last row |
| max_scan_i | input | 5 | Scan lines per row minus one |
| start_addr_i | input | 14 | Refresh address at the top of the frame |
| phase_i | input | 1 | Byte-phase bit placed at video address bit 0 |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| ma_o | output | 14 | Refresh memory address |
| ra_o | output | 5 | Scan-line (raster) address |
| vid_addr_o | output | 16 | Interleaved video memory address |

## Verification
ma_o, ra_o, hsync_o and vsync_o are registered, so a setting that is stable at a rising edge shows in these outputs one clock later. de_o and vid_addr_o follow the inputs and the present state with no delay. The bench holds its inputs across each rising edge, advances its reference model once per edge using those inputs, and compares one time unit after the next falling edge. Pulse widths are also measured by counting sync-high cycles over windows that cover a whole number of lines or frames, after at least a full frame of settling, so a count does not depend on where in the frame the window begins.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef enum logic [2:0] {
    VAR_HNONE_VPROG = 3'd0,
    VAR_HNONE_VFIX  = 3'd1,
    VAR_H16_VFIX    = 3'd2,
    VAR_BOTH16      = 3'd3
  } variant_e;

  localparam int          RUN_W    = 5;
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(16);
endpackage

// File: rtl/crt_sync_decode.sv
module crt_sync_decode
  import crt_pkg::*;
(
  input  logic [2:0]       variant_i,
  input  logic [7:0]       width_i,
  output logic [RUN_W-1:0] h_w_o,
  output logic [RUN_W-1:0] v_w_o
);
  logic [RUN_W-1:0] h_raw, v_raw, h_z16, v_z16;

  assign h_raw = RUN_W'(width_i[3:0]);
  assign v_raw = RUN_W'(width_i[7:4]);
  assign h_z16 = (h_raw == '0) ? RUN_FULL : h_raw;
  assign v_z16 = (v_raw == '0) ? RUN_FULL : v_raw;

  always_comb begin
    unique case (variant_i)
      VAR_HNONE_VPROG: begin h_w_o = h_raw; v_w_o = v_z16;    end
      VAR_HNONE_VFIX:  begin h_w_o = h_raw; v_w_o = RUN_FULL; end
      VAR_H16_VFIX:    begin h_w_o = h_z16; v_w_o = RUN_FULL; end
      default:         begin h_w_o = h_z16; v_w_o = v_z16;    end
    endcase
  end
endmodule

// File: rtl/crt_h_timing.sv
module crt_h_timing
  import crt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    total_i,
  input  logic [CW-1:0]    pos_i,
  input  logic [RUN_W-1:0] width_i,
  output logic [CW-1:0]    cnt_o,
  output logic             line_end_o,
  output logic             sync_o
);
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             act_q;
  logic [RUN_W-1:0] run_q;

  assign line_end_o = (cnt_q >= total_i);
  assign cnt_d      = line_end_o ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      run_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (cnt_d == pos_i && width_i != '0) begin
        act_q <= 1'b1;
        run_q <= RUN_W'(1);
      end else if (act_q && run_q >= width_i) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        run_q <= run_q + RUN_W'(1);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign sync_o = act_q;
endmodule

// File: rtl/crt_v_timing.sv
module crt_v_timing
  import crt_pkg::*;
#(
  parameter int RW = 7,
  parameter int SW = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_end_i,
  input  logic [SW-1:0]    max_scan_i,
  input  logic [RW-1:0]    v_total_i,
  input  logic [SW-1:0]    v_adj_i,
  input  logic [RW-1:0]    v_sync_pos_i,
  input  logic [RUN_W-1:0] width_i,
  output logic [SW-1:0]    sl_o,
  output logic [RW-1:0]    row_o,
  output logic             frame_end_o,
  output logic             row_end_o,
  output logic             sync_o
);
  logic [SW-1:0]    sl_q, sl_d;
  logic [RW-1:0]    row_q, row_d;
  logic             adj_q, adj_d;
  logic [SW:0]      sl_inc;
  logic             last_line, last_row;
  logic             act_q;
  logic [RUN_W-1:0] run_q;

  assign sl_inc      = {1'b0, sl_q} + (SW+1)'(1);
  assign last_line   = !adj_q && (sl_q >= max_scan_i);
  assign last_row    = (row_q >= v_total_i);
  assign frame_end_o = line_end_i && (adj_q ? (sl_inc >= {1'b0, v_adj_i})
                                            : (last_line && last_row && v_adj_i == '0));
  assign row_end_o   = line_end_i && last_line && !frame_end_o;

  always_comb begin
    sl_d  = sl_q;
    row_d = row_q;
    adj_d = adj_q;
    if (frame_end_o) begin
      sl_d  = '0;
      row_d = '0;
      adj_d = 1'b0;
    end else if (row_end_o) begin
      sl_d  = '0;
      row_d = row_q + RW'(1);
      adj_d = last_row;  // entering the adjust lines
    end else if (line_end_i) begin
      sl_d  = sl_inc[SW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sl_q  <= '0;
      row_q <= '0;
      adj_q <= 1'b0;
      act_q <= 1'b0;
      run_q <= '0;
    end else begin
      sl_q  <= sl_d;
      row_q <= row_d;
      adj_q <= adj_d;
      if (line_end_i) begin
        if (sl_d == '0 && row_d == v_sync_pos_i && width_i != '0) begin
          act_q <= 1'b1;
          run_q <= RUN_W'(1);
        end else if (act_q && run_q >= width_i) begin
          act_q <= 1'b0;
        end else if (act_q) begin
          run_q <= run_q + RUN_W'(1);
        end
      end
    end
  end

  assign sl_o   = sl_q;
  assign row_o  = row_q;
  assign sync_o = act_q;
endmodule

// File: rtl/crt_addr_gen.sv
module crt_addr_gen #(
  parameter int CW = 8,
  parameter int MW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_end_i,
  input  logic          row_end_i,
  input  logic          frame_end_i,
  input  logic [CW-1:0] h_disp_i,
  input  logic [MW-1:0] start_addr_i,
  output logic [MW-1:0] ma_o
);
  logic [MW-1:0] base_q, ma_q, base_inc;

  assign base_inc = base_q + MW'(h_disp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ma_q   <= '0;
    end else if (frame_end_i) begin
      base_q <= start_addr_i;
      ma_q   <= start_addr_i;
    end else if (row_end_i) begin
      base_q <= base_inc;
      ma_q   <= base_inc;
    end else if (line_end_i) begin
      ma_q   <= base_q;
    end else begin
      ma_q   <= ma_q + MW'(1);
    end
  end

  assign ma_o = ma_q;
endmodule

// File: rtl/crt_raster_gen.sv
module crt_raster_gen
  import crt_pkg::*;
#(
  parameter int CW = 8,
  parameter int RW = 7,
  parameter int SW = 5,
  parameter int MW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    variant_i,
  input  logic [CW-1:0] h_total_i,
  input  logic [CW-1:0] h_disp_i,
  input  logic [CW-1:0] h_sync_pos_i,
  input  logic [7:0]    sync_width_i,
  input  logic [RW-1:0] v_total_i,
  input  logic [RW-1:0] v_disp_i,
  input  logic [RW-1:0] v_sync_pos_i,
  input  logic [SW-1:0] v_adj_i,
  input  logic [SW-1:0] max_scan_i,
  input  logic [MW-1:0] start_addr_i,
  input  logic          phase_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [MW-1:0] ma_o,
  output logic [SW-1:0] ra_o,
  output logic [15:0]   vid_addr_o
);
  logic [RUN_W-1:0] h_w, v_w;
  logic [CW-1:0]    h_cnt;
  logic [RW-1:0]    row_cnt;
  logic             line_end, row_end, frame_end;

  crt_sync_decode u_dec (
    .variant_i (variant_i),
    .width_i   (sync_width_i),
    .h_w_o     (h_w),
    .v_w_o     (v_w)
  );

  crt_h_timing #(.CW(CW)) u_h (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .total_i    (h_total_i),
    .pos_i      (h_sync_pos_i),
    .width_i    (h_w),
    .cnt_o      (h_cnt),
    .line_end_o (line_end),
    .sync_o     (hsync_o)
  );

  crt_v_timing #(.RW(RW), .SW(SW)) u_v (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_end_i   (line_end),
    .max_scan_i   (max_scan_i),
    .v_total_i    (v_total_i),
    .v_adj_i      (v_adj_i),
    .v_sync_pos_i (v_sync_pos_i),
    .width_i      (v_w),
    .sl_o         (ra_o),
    .row_o        (row_cnt),
    .frame_end_o  (frame_end),
    .row_end_o    (row_end),
    .sync_o       (vsync_o)
  );

  crt_addr_gen #(.CW(CW), .MW(MW)) u_a (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_end_i   (line_end),
    .row_end_i    (row_end),
    .frame_end_i  (frame_end),
    .h_disp_i     (h_disp_i),
    .start_addr_i (start_addr_i),
    .ma_o         (ma_o)
  );

  assign de_o       = (h_cnt < h_disp_i) && (row_cnt < v_disp_i);
  // address interleave fixed by the memory map: MW=14, SW>=3
  assign vid_addr_o = {ma_o[13:12], ra_o[2:0], ma_o[9:0], phase_i};
endmodule

// File: rtl/crt_raster_chk.sv
module crt_raster_chk #(
  parameter int CW = 8,
  parameter int SW = 5,
  parameter int MW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    variant_i,
  input logic [7:0]    sync_width_i,
  input logic [CW-1:0] h_total_i,
  input logic [MW-1:0] start_addr_i,
  input logic          hsync_o,
  input logic [MW-1:0] ma_o,
  input logic [SW-1:0] ra_o,
  input logic [CW-1:0] h_cnt,
  input logic          frame_end
);
  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk_i) rst_seen_q <= !rst_ni;

  AST_RESET_LOW: assert property (@(posedge clk_i)
    (rst_seen_q && !rst_ni) |-> (ma_o == '0 && ra_o == '0 && !hsync_o)); // R1

  AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(h_cnt >= h_total_i) |-> (h_cnt == '0)); // R2

  AST_FRAME_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_end) |-> (ma_o == $past(start_addr_i) && ra_o == '0)); // R5

  AST_HS_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (variant_i <= 3'd1 && sync_width_i[3:0] == 4'd0) |=> !hsync_o); // R8
endmodule

bind crt_raster_gen crt_raster_chk #(.CW(CW), .SW(SW), .MW(MW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .variant_i    (variant_i),
  .sync_width_i (sync_width_i),
  .h_total_i    (h_total_i),
  .start_addr_i (start_addr_i),
  .hsync_o      (hsync_o),
  .ma_o         (ma_o),
  .ra_o         (ra_o),
  .h_cnt        (h_cnt),
  .frame_end    (frame_end)
);

// File: tb/sim_crt_raster_gen.sv
module sim_crt_raster_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  variant;
  logic [7:0]  h_total, h_disp, h_pos, sw;
  logic [6:0]  v_total, v_disp, v_pos;
  logic [4:0]  v_adj, max_scan;
  logic [13:0] start_addr;
  logic        phase = 1'b0;
  logic        hsync, vsync, de;
  logic [13:0] ma;
  logic [4:0]  ra;
  logic [15:0] vid;

  int checks = 0, fails = 0;
  int hs_acc = 0, vs_acc = 0;
  bit done = 0;
  int m_h, m_sl, m_row, m_adj, m_base, m_ma, m_hs, m_hr, m_vs, m_vr;

  always #(CLK_PERIOD/2) clk = ~clk;

  crt_raster_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .variant_i(variant),
    .h_total_i(h_total), .h_disp_i(h_disp), .h_sync_pos_i(h_pos),
    .sync_width_i(sw), .v_total_i(v_total), .v_disp_i(v_disp),
    .v_sync_pos_i(v_pos), .v_adj_i(v_adj), .max_scan_i(max_scan),
    .start_addr_i(start_addr), .phase_i(phase),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .ma_o(ma), .ra_o(ra),
    .vid_addr_o(vid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int hw_of(input int v, input int w);
    int r = w & 15;
    if (v <= 1) return r;
    return (r == 0) ? 16 : r;
  endfunction

  function automatic int vw_of(input int v, input int w);
    int r = (w >> 4) & 15;
    if (v == 1 || v == 2) return 16;
    return (r == 0) ? 16 : r;
  endfunction

  task automatic model_reset();
    m_h = 0; m_sl = 0; m_row = 0; m_adj = 0; m_base = 0; m_ma = 0;
    m_hs = 0; m_hr = 0; m_vs = 0; m_vr = 0;
  endtask

  // one rising edge of the reference model, using the inputs held across it
  task automatic model_step();
    int hw = hw_of(int'(variant), int'(sw));
    int vw = vw_of(int'(variant), int'(sw));
    bit le = (m_h >= int'(h_total));
    int hn = le ? 0 : m_h + 1;
    bit ll = !m_adj && (m_sl >= int'(max_scan));
    bit lr = (m_row >= int'(v_total));
    bit fe = le && (m_adj ? (m_sl + 1 >= int'(v_adj)) : (ll && lr && v_adj == 0));
    bit re = le && ll && !fe;
    int sn = m_sl, rn = m_row, an = m_adj;
    if (hn == int'(h_pos) && hw != 0) begin m_hs = 1; m_hr = 1; end
    else if (m_hs && m_hr >= hw) m_hs = 0;
    else if (m_hs) m_hr++;
    if (fe) begin sn = 0; rn = 0; an = 0; end
    else if (re) begin sn = 0; rn = (m_row + 1) % 128; an = lr; end
    else if (le) sn = m_sl + 1;
    if (le) begin
      if (sn == 0 && rn == int'(v_pos)) begin m_vs = 1; m_vr = 1; end
      else if (m_vs && m_vr >= vw) m_vs = 0;
      else if (m_vs) m_vr++;
    end
    if (fe) begin m_base = int'(start_addr); m_ma = m_base; end
    else if (re) begin m_base = (m_base + int'(h_disp)) % 16384; m_ma = m_base; end
    else if (le) m_ma = m_base;
    else m_ma = (m_ma + 1) % 16384;
    m_h = hn; m_sl = sn; m_row = rn; m_adj = an;
  endtask

  task automatic cycle();
    int ev;
    bit ed;
    if (!rst_ni) model_reset(); else model_step();
    @(negedge clk);
    phase = 1'($urandom);
    #1;
    ed = (m_h < int'(h_disp)) && (m_row < int'(v_disp));
    ev = (((m_ma >> 12) & 3) << 14) | ((m_sl & 7) << 11) | ((m_ma & 1023) << 1) | int'(phase);
    chk(int'(ma) == m_ma, "R2,R3,R5 ma", int'(ma), m_ma);
    chk(int'(ra) == m_sl, "R3,R4 ra", int'(ra), m_sl);
    chk(de == ed, "R6 de", int'(de), int'(ed));
    chk(int'(hsync) == m_hs, "R7 hsync", int'(hsync), m_hs);
    chk(int'(vsync) == m_vs, "R9 vsync", int'(vsync), m_vs);
    chk(int'(vid) == ev, "R11 vid_addr", int'(vid), ev);
    hs_acc += int'(hsync);
    vs_acc += int'(vsync);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic set_cfg(input int v, input int ht, input int hd, input int hp, input int w,
                         input int vt, input int vd, input int vp, input int va,
                         input int ms, input int sa);
    variant = 3'(v); h_total = 8'(ht); h_disp = 8'(hd); h_pos = 8'(hp); sw = 8'(w);
    v_total = 7'(vt); v_disp = 7'(vd); v_pos = 7'(vp); v_adj = 5'(va);
    max_scan = 5'(ms); start_addr = 14'(sa);
  endtask

  task automatic rand_cfg();
    int ht = 3 + $urandom % 13;
    int sa = ($urandom % 4 == 0) ? 16'h3FF0 + $urandom % 16 : $urandom % 16384;
    set_cfg($urandom % 8, ht, $urandom % (ht + 2), $urandom % (ht + 1), $urandom % 256,
            $urandom % 5, $urandom % 7, $urandom % 7, $urandom % 4, $urandom % 4, sa);
  endtask

  // count sync-high cycles over a window after settling
  task automatic measure(input int settle, input int win, input int exp_h, input int exp_v,
                         input string tag);
    run(settle);
    hs_acc = 0; vs_acc = 0;
    run(win);
    if (exp_h >= 0) chk(hs_acc == exp_h, {tag, " hsync count"}, hs_acc, exp_h);
    if (exp_v >= 0) chk(vs_acc == exp_v, {tag, " vsync count"}, vs_acc, exp_v);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    set_cfg(0, 9, 6, 7, 8'h22, 3, 2, 1, 2, 1, 14'h0100);
    run(4);
    chk(ma == 0 && ra == 0 && vid[15:1] == 0, "R1 reset address", int'(vid), 0);
    chk(!hsync && !vsync, "R1 reset sync", int'({hsync, vsync}), 0);
    #1 rst_ni = 1'b1;
    run(1);
    chk(ma == 14'd1, "R1 first step after release", int'(ma), 1);
    run(600);

    // R8: horizontal width decode, 40-char lines, windows of 10 lines
    set_cfg(1, 39, 30, 10, 8'h00, 29, 20, 2, 0, 0, 0);
    measure(80, 400, 0, -1, "R8 var1 zero");
    set_cfg(2, 39, 30, 10, 8'hF0, 29, 20, 2, 0, 0, 0);
    measure(80, 400, 160, -1, "R8 var2 zero->16");
    set_cfg(0, 39, 30, 10, 8'h35, 29, 20, 2, 0, 0, 0);
    measure(80, 400, 50, -1, "R8 var0 width5");

    // R10: vertical width decode, 10-char lines, 30-line frames (300 cycles)
    set_cfg(0, 9, 8, 3, 8'h04, 29, 20, 2, 0, 0, 0);
    measure(700, 600, -1, 320, "R10 var0 zero->16");
    set_cfg(0, 9, 8, 3, 8'h34, 29, 20, 2, 0, 0, 0);
    measure(700, 600, -1, 60, "R10 var0 three");
    set_cfg(1, 9, 8, 3, 8'h34, 29, 20, 2, 0, 0, 0);
    measure(700, 600, -1, 320, "R10 var1 fixed");
    set_cfg(3, 39, 30, 10, 8'h00, 29, 20, 2, 0, 0, 0);
    measure(2500, 2400, 960, 1280, "R8,R10 var3 both zero");

    // R4: adjust lines with a wrapping start address
    set_cfg(4, 7, 5, 6, 8'h21, 2, 2, 1, 3, 2, 14'h3FFE);
    run(800);
    set_cfg(0, 5, 9, 5, 8'h11, 0, 3, 0, 0, 0, 14'h3FFF);
    run(300);

    for (int k = 0; k < 60; k++) begin
      rand_cfg();
      run(200 + $urandom % 500);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule